// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits at the front of a simple in-order processor's fetch stage. Each cycle it receives the instruction bytes that begin at the current program counter, as many as the longest instruction needs. It works out the length of the instruction from the operation code in the first byte. It then splits the bytes into the operation code and function nibbles, an optional pair of register identifiers and an optional constant word.

It also owns the program counter register. The address of the next sequential instruction is the current PC plus the length of the current instruction. The PC moves to that address on every clock edge, with two exceptions. An unknown operation code makes the PC hold. A redirect strobe loads an externally supplied address instead, and this takes priority over both other cases.

The constant width is a parameter. The instruction window is two bytes wider than the constant, and the longer instruction lengths follow from the constant width.

Top module: `ifetch_decoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `pc_out` equals the parameter `RESET_PC` (default 0x100).
- R2: Byte k of the window (bits 8k+7:8k) is the byte at address PC+k. `op_code` is bits 7:4 of byte 0 and `op_fn` is bits 3:0 of byte 0, for every byte value.
- R3: For operation codes 2, 3, 4, 5, 6, 0xA and 0xB a register byte is byte 1. For these codes `reg_a` is bits 7:4 of byte 1 and `reg_b` is bits 3:0 of byte 1. For every other code both outputs are 8, which means no register.
- R4: For codes 3, 4 and 5 the constant is taken from bytes 2 to 5. For codes 7 and 8 it is taken from bytes 1 to 4. The lowest-addressed byte is the least significant one. For every other code `const_val` is 0.
- R5: `next_pc` equals `pc_out` plus the length, taken modulo 2^32. The length is 1 for codes 0, 1 and 9, 2 for codes 2, 6, 0xA and 0xB, 5 for codes 7 and 8, and 6 for codes 3, 4 and 5.
- R6: `bad_code` is 1 exactly when the operation code is 0xC to 0xF. For those codes the length is 1, the register outputs are 8 and the constant is 0.
- R7: At a clock edge with `redirect_valid` low and a known code, `pc_out` takes the value of `next_pc`. This includes wrap-around past 0xFFFFFFFF.
- R8: At a clock edge with `redirect_valid` low and `bad_code` high, `pc_out` keeps its value.
- R9: At a clock edge with `redirect_valid` high, `pc_out` takes `redirect_pc`, whatever the operation code is, known or unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_bytes | input | 48 | Instruction bytes starting at the PC, byte 0 in bits 7:0 |
| redirect_valid | input | 1 | Load `redirect_pc` at the next edge |
| redirect_pc | input | 32 | Address to load on a redirect |
| pc_out | output | 32 | Current program counter |
| op_code | output | 4 | Operation code nibble |
| op_fn | output | 4 | Function nibble |
| reg_a | output | 4 | First register identifier, or 8 |
| reg_b | output | 4 | Second register identifier, or 8 |
| const_val | output | 32 | Assembled constant word, or 0 |
| next_pc | output | 32 | Address of the next sequential instruction |
| bad_code | output | 1 | Unknown operation code |

## Verification
Two PC-update functions can land on the same edge. A redirect can arrive while the window holds an unknown code, and it can also arrive while the window holds a known code. The bench raises `redirect_valid` in the same cycle that it presents a 0xF0 byte, and again with a six-byte instruction. After the edge it checks that `pc_out` shows the redirect address in both cases, and neither the held PC nor the sequential address. A full sweep of all 256 first-byte values then covers each of hold and advance on its own.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
   typedef enum logic [3:0] {
      OP_HALT  = 4'h0,
      OP_NOP   = 4'h1,
      OP_RRMOV = 4'h2,
      OP_IRMOV = 4'h3,
      OP_RMMOV = 4'h4,
      OP_MRMOV = 4'h5,
      OP_ALU   = 4'h6,
      OP_JUMP  = 4'h7,
      OP_CALL  = 4'h8,
      OP_RET   = 4'h9,
      OP_PUSH  = 4'hA,
      OP_POP   = 4'hB
   } opcode_e;

   typedef struct packed {
      logic known;
      logic has_reg;
      logic has_const;
   } fmt_t;

   function automatic fmt_t fmt_of(logic [3:0] code);
      fmt_t f;
      f = '{known: 1'b1, has_reg: 1'b0, has_const: 1'b0};
      case (code)
         OP_HALT, OP_NOP, OP_RET:         ;
         OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: f.has_reg = 1'b1;
         OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
            f.has_reg   = 1'b1;
            f.has_const = 1'b1;
         end
         OP_JUMP, OP_CALL:                f.has_const = 1'b1;
         default:                         f.known = 1'b0;
      endcase
      return f;
   endfunction
endpackage

// File: rtl/ifd_format_decode.sv
module ifd_format_decode
   import ifd_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   parameter int LEN_W       = 3
) (
   input  logic [3:0]       code,
   output logic             known,
   output logic             has_reg,
   output logic             has_const,
   output logic [LEN_W-1:0] len
);
   fmt_t fmt;

   always_comb begin
      fmt       = fmt_of(code);
      known     = fmt.known;
      has_reg   = fmt.has_reg;
      has_const = fmt.has_const;
      len       = LEN_W'(1)
                + (fmt.has_reg   ? LEN_W'(1)           : LEN_W'(0))
                + (fmt.has_const ? LEN_W'(CONST_BYTES) : LEN_W'(0));
   end
endmodule

// File: rtl/ifd_field_extract.sv
module ifd_field_extract #(
   parameter int CONST_BYTES = 4,
   parameter int WIN_BYTES   = 6,
   parameter int NOREG_ID    = 8
) (
   input  logic [WIN_BYTES*8-1:0]   window,
   input  logic                     has_reg,
   input  logic                     has_const,
   output logic [3:0]               op_fn,
   output logic [3:0]               reg_a,
   output logic [3:0]               reg_b,
   output logic [CONST_BYTES*8-1:0] const_val
);
   localparam int WORD_W = CONST_BYTES * 8;

   logic [WORD_W-1:0] word_after_reg;
   logic [WORD_W-1:0] word_after_op;

   for (genvar b = 0; b < CONST_BYTES; b++) begin : g_cbyte
      assign word_after_reg[8*b +: 8] = window[8*(2+b) +: 8];
      assign word_after_op[8*b +: 8]  = window[8*(1+b) +: 8];
   end

   always_comb begin
      op_fn = window[3:0];
      if (has_reg) begin
         reg_a = window[15:12];
         reg_b = window[11:8];
      end else begin
         reg_a = 4'(NOREG_ID);
         reg_b = 4'(NOREG_ID);
      end
      if (!has_const)
         const_val = '0;
      else if (has_reg)
         const_val = word_after_reg;
      else
         const_val = word_after_op;
   end
endmodule

// File: rtl/ifd_pc_unit.sv
module ifd_pc_unit #(
   parameter int              ADDR_W   = 32,
   parameter int              LEN_W    = 3,
   parameter logic [ADDR_W-1:0] RESET_PC = 32'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  len,
   input  logic              known,
   input  logic              redir_v,
   input  logic [ADDR_W-1:0] redir_pc,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] seq_pc
);
   assign seq_pc = pc + ADDR_W'(len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= RESET_PC;
      else if (redir_v)
         pc <= redir_pc;
      else if (known)
         pc <= seq_pc;
   end
endmodule

// File: rtl/ifetch_decoder.sv
module ifetch_decoder #(
   parameter int              ADDR_W   = 32,
   parameter int              WORD_W   = 32,
   parameter int              NOREG_ID = 8,
   parameter logic [ADDR_W-1:0] RESET_PC = 32'h100,
   localparam int             CONST_BYTES = WORD_W / 8,
   localparam int             WIN_BYTES   = CONST_BYTES + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIN_BYTES*8-1:0] win_bytes,
   input  logic                   redirect_valid,
   input  logic [ADDR_W-1:0]      redirect_pc,
   output logic [ADDR_W-1:0]      pc_out,
   output logic [3:0]             op_code,
   output logic [3:0]             op_fn,
   output logic [3:0]             reg_a,
   output logic [3:0]             reg_b,
   output logic [WORD_W-1:0]      const_val,
   output logic [ADDR_W-1:0]      next_pc,
   output logic                   bad_code
);
   localparam int LEN_W = $clog2(WIN_BYTES + 1);

   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a positive multiple of 8");
   end
   if (NOREG_ID < 0 || NOREG_ID > 15) begin : g_bad_noreg
      $error("NOREG_ID must fit a nibble");
   end

   logic             known;
   logic             has_reg;
   logic             has_const;
   logic [LEN_W-1:0] len;

   assign op_code  = win_bytes[7:4];
   assign bad_code = !known;

   ifd_format_decode #(.CONST_BYTES(CONST_BYTES), .LEN_W(LEN_W)) u_fmt (
      .code(op_code), .known(known), .has_reg(has_reg),
      .has_const(has_const), .len(len));

   ifd_field_extract #(.CONST_BYTES(CONST_BYTES), .WIN_BYTES(WIN_BYTES),
                       .NOREG_ID(NOREG_ID)) u_fld (
      .window(win_bytes), .has_reg(has_reg), .has_const(has_const),
      .op_fn(op_fn), .reg_a(reg_a), .reg_b(reg_b), .const_val(const_val));

   ifd_pc_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_PC(RESET_PC)) u_pc (
      .clk(clk), .rst_n(rst_n), .len(len), .known(known),
      .redir_v(redirect_valid), .redir_pc(redirect_pc),
      .pc(pc_out), .seq_pc(next_pc));
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_code,
   input logic [3:0]        reg_a,
   input logic [3:0]        reg_b,
   input logic              bad_code,
   input logic              redirect_valid,
   input logic [ADDR_W-1:0] redirect_pc,
   input logic [ADDR_W-1:0] pc_out,
   input logic [ADDR_W-1:0] next_pc
);
   logic [ADDR_W-1:0] step;
   assign step = next_pc - pc_out;

   assert_redirect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> pc_out == $past(redirect_pc));

   assert_hold_on_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_code && !redirect_valid) |=> pc_out == $past(pc_out));

   assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bad_code && !redirect_valid) |=> pc_out == $past(next_pc));

   assert_step_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step == 1 || step == 2 || step == 5 || step == 6);

   assert_bad_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bad_code |-> (step == 1 && reg_a == 4'd8 && reg_b == 4'd8));

   assert_noreg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 4'h0 || op_code == 4'h1 || op_code == 4'h7 ||
       op_code == 4'h8 || op_code == 4'h9) |-> (reg_a == 4'd8 && reg_b == 4'd8));
endmodule

bind ifetch_decoder ifd_checker #(.ADDR_W(ADDR_W)) u_ifd_checker (
   .clk(clk), .rst_n(rst_n), .op_code(op_code), .reg_a(reg_a), .reg_b(reg_b),
   .bad_code(bad_code), .redirect_valid(redirect_valid),
   .redirect_pc(redirect_pc), .pc_out(pc_out), .next_pc(next_pc));

// File: tb/test_ifetch_decoder.sv
module test_ifetch_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] win_bytes = '0;
   logic        redirect_valid = 1'b0;
   logic [31:0] redirect_pc = '0;
   logic [31:0] pc_out, const_val, next_pc;
   logic [3:0]  op_code, op_fn, reg_a, reg_b;
   logic        bad_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   ifetch_decoder i_ifetch_decoder (
      .clk(clk), .rst_n(rst_n), .win_bytes(win_bytes),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .pc_out(pc_out), .op_code(op_code), .op_fn(op_fn), .reg_a(reg_a),
      .reg_b(reg_b), .const_val(const_val), .next_pc(next_pc),
      .bad_code(bad_code));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int len_of(logic [3:0] c);
      case (c)
         4'h0, 4'h1, 4'h9:             return 1;
         4'h2, 4'h6, 4'hA, 4'hB:       return 2;
         4'h7, 4'h8:                   return 5;
         4'h3, 4'h4, 4'h5:             return 6;
         default:                      return 1;
      endcase
   endfunction

   function automatic logic [7:0] fill(int code, int k);
      return 8'((code * 7 + k * 37 + 11) & 255);
   endfunction

   task automatic redirect_to(logic [31:0] a);
      @(negedge clk);
      redirect_valid = 1'b1;
      redirect_pc    = a;
      @(negedge clk);
      redirect_valid = 1'b0;
   endtask

   // Decode one first-byte value at PC x, then check the PC after one edge
   task automatic sweep_one(int b0, logic [31:0] x);
      logic [3:0]  c;
      logic [31:0] exp_const;
      bit          hr, hc, bad;
      int          L;
      redirect_to(x);
      win_bytes[7:0] = 8'(b0);
      for (int k = 1; k < 6; k++) win_bytes[8*k +: 8] = fill(b0, k);
      c   = 4'(b0 >> 4);
      L   = len_of(c);
      bad = (c > 4'hB);
      hr  = (L == 2 || L == 6);
      hc  = (L >= 5) && !bad;
      if (!hc)      exp_const = 32'h0;
      else if (hr)  exp_const = {fill(b0,5), fill(b0,4), fill(b0,3), fill(b0,2)};
      else          exp_const = {fill(b0,4), fill(b0,3), fill(b0,2), fill(b0,1)};
      #1;
      chk("R2 op_code", 32'(op_code), 32'(c));
      chk("R2 op_fn", 32'(op_fn), 32'(b0 & 15));
      chk("R3 reg_a", 32'(reg_a), hr ? 32'(fill(b0,1) >> 4) : 32'd8);
      chk("R3 reg_b", 32'(reg_b), hr ? 32'(fill(b0,1) & 8'hF) : 32'd8);
      chk("R4 const_val", const_val, exp_const);
      chk("R5 next_pc", next_pc, x + 32'(L));
      chk("R6 bad_code", 32'(bad_code), 32'(bad));
      @(negedge clk);
      if (bad) chk("R8 pc held", pc_out, x);
      else     chk("R7 pc advanced", pc_out, x + 32'(L));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", pc_out, 32'h100);
      rst_n = 1'b1;
      #1;
      chk("R1 pc after release", pc_out, 32'h100);

      for (int b = 0; b < 256; b++) sweep_one(b, 32'h1000 + 32'(b) * 16);

      // R7 wrap-around with a six-byte instruction
      sweep_one(8'h30, 32'hFFFF_FFFE);

      // R9 redirect in the same cycle as an unknown code
      redirect_to(32'h500);
      win_bytes[7:0] = 8'hF0;
      redirect_valid = 1'b1;
      redirect_pc    = 32'h2222;
      @(negedge clk);
      redirect_valid = 1'b0;
      chk("R9 redirect over hold", pc_out, 32'h2222);

      // R9 redirect in the same cycle as a known six-byte code
      win_bytes[7:0] = 8'h30;
      redirect_valid = 1'b1;
      redirect_pc    = 32'h3333;
      @(negedge clk);
      redirect_valid = 1'b0;
      chk("R9 redirect over advance", pc_out, 32'h3333);

      // R8 repeated hold across several edges
      win_bytes[7:0] = 8'hC5;
      repeat (3) @(negedge clk);
      chk("R8 pc held three edges", pc_out, 32'h3333);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule